// File: doc/BRIEF.md
# Multi-Pass Ray State Scheduler

This block steers a fixed array of rays through a renderer whose kernels run one at a time over the whole array. Each ray holds a small stage tag that names the kernel it needs next. The four kernels are generating the primary ray, stepping through the acceleration grid, testing triangles and shading. In each pass the block walks the array once, in ray index order. It issues only the rays whose tag equals the active kernel and holds every other ray back unchanged. When the kernel reports an outcome for an issued ray, that ray's tag moves to its next stage.

After a pass has ended, the block counts how many rays wait in each stage and starts the kernel with the most waiting rays. When no ray is left outside the terminated stage, it raises a one-cycle frame-done pulse and goes idle. The surrounding kernel pipeline reads the issued ray indices and returns one outcome for each issued ray. A pass lasts one cycle per ray plus a drain window of `KERNEL_LAT` cycles, so results that arrive within that latency are still taken.

Top module: `ray_pass_scheduler`

## Requirements
- R1: A `frame_start` pulse sets every tag to the generation stage. It also abandons any pass in progress. The first pass after it runs the generation kernel and issues all `NUM_RAYS` rays.
- R2: A pass holds `pass_active` high for exactly `NUM_RAYS + KERNEL_LAT` cycles. During the first `NUM_RAYS` of those cycles it visits ray 0 up to ray `NUM_RAYS-1`, one ray per cycle, and issues each matching ray once.
- R3: Only rays whose tag equals the active kernel are issued. Masked rays keep their tags unchanged. A result is ignored if its ray was not issued in the current pass, if it is a second result for the same ray, or if it arrives outside the pass window.
- R4: Generation outcome (`res_code[0]`): 1 (ray hits the scene box) moves the ray to traversal; 0 terminates it.
- R5: Traversal outcome: code 2'b01 (ray left the grid) terminates the ray; 2'b10 (non-empty cell) moves it to intersection; 2'b00 and 2'b11 keep it in traversal.
- R6: Intersection outcome (`res_code[0]`): 1 (hit) moves the ray to shading; 0 (no hit in the cell) returns it to traversal.
- R7: Shading outcome (`res_code[0]`): 1 (secondary ray spawned) returns the ray to traversal; 0 terminates it.
- R8: In the single cycle after a pass ends, `pass_done` is high and `pass_count` holds the number of rays issued in that pass.
- R9: The next kernel is the stage with the most waiting rays. Ties go first to intersection, then traversal, then shading, then generation. Kernel codes: generation 0, traversal 1, intersection 2, shading 3. The terminated tag is 3'b111.
- R10: Once every tag is terminated, `frame_done` pulses for one cycle and no further pass starts until the next `frame_start`.
- R11: After reset all tags are terminated, the block is idle and every output is low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous release |
| frame_start | input | 1 | Pulse that restarts all rays in generation |
| issue_valid | output | 1 | Ray `issue_id` is sent to the active kernel this cycle |
| issue_id | output | $clog2(NUM_RAYS) | Index of the issued ray |
| res_valid | input | 1 | Kernel outcome present |
| res_id | input | $clog2(NUM_RAYS) | Ray the outcome belongs to |
| res_code | input | 2 | Outcome code, meaning set by the active kernel |
| pass_active | output | 1 | A pass (visit or drain cycle) is running |
| pass_kernel | output | 2 | Kernel of the current or just-finished pass |
| pass_count | output | $clog2(NUM_RAYS+1) | Rays issued in the current pass |
| pass_done | output | 1 | One-cycle pulse after a pass ends |
| frame_done | output | 1 | One-cycle pulse once all rays are terminated |

## Verification
Two things often fall in the same cycle: the write-back of an outcome for an earlier ray, and the issue decision for the ray now being visited. The bench's kernel model returns every outcome exactly `KERNEL_LAT` cycles after its issue. Because of that, a write-back lands in each visit cycle. The last write-back lands in the final drain cycle, just before the next stage choice. The results are judged by the chosen kernel and issue count of every later pass, including an intersection/shading tie. Stray results sent into a pick cycle or for masked rays must leave those counts unchanged.

// File: rtl/ray_sched_pkg.sv
package ray_sched_pkg;

    localparam int TAG_W    = 3;
    localparam int N_STAGES = 4;

    // Stage tags; the low two bits of a live tag equal its kernel code
    localparam logic [TAG_W-1:0] TAG_GEN   = 3'd0;
    localparam logic [TAG_W-1:0] TAG_TRAV  = 3'd1;
    localparam logic [TAG_W-1:0] TAG_ISECT = 3'd2;
    localparam logic [TAG_W-1:0] TAG_SHADE = 3'd3;
    localparam logic [TAG_W-1:0] TAG_TERM  = 3'd7;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PICK  = 2'd1,
        PH_SCAN  = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;

    // Stage a ray moves to when kernel `kern` reports outcome `code`
    function automatic logic [TAG_W-1:0] advance_tag(input logic [1:0] kern,
                                                     input logic [1:0] code);
        logic [TAG_W-1:0] nxt;
        unique case (kern)
            2'd0: nxt = code[0] ? TAG_TRAV : TAG_TERM;
            2'd1: begin
                if (code == 2'b01)      nxt = TAG_TERM;
                else if (code == 2'b10) nxt = TAG_ISECT;
                else                    nxt = TAG_TRAV;
            end
            2'd2: nxt = code[0] ? TAG_SHADE : TAG_TRAV;
            default: nxt = code[0] ? TAG_TRAV : TAG_TERM;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/ray_tag_store.sv
module ray_tag_store
    import ray_sched_pkg::*;
#(
    parameter int NUM_RAYS = 8,
    localparam int IDW = (NUM_RAYS > 1) ? $clog2(NUM_RAYS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear_all,
    input  logic                      wr_en,
    input  logic [IDW-1:0]            wr_id,
    input  logic [TAG_W-1:0]          wr_tag,
    output logic [NUM_RAYS*TAG_W-1:0] tags_o
);

    typedef struct packed {
        logic [NUM_RAYS-1:0][TAG_W-1:0] tag;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear_all) begin
            for (int r = 0; r < NUM_RAYS; r++) begin
                s_d.tag[r] = TAG_GEN;
            end
        end else if (wr_en && (int'(wr_id) < NUM_RAYS)) begin
            s_d.tag[wr_id] = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_RAYS; r++) begin
                s_q.tag[r] <= TAG_TERM;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign tags_o = s_q.tag;

endmodule

// File: rtl/stage_census.sv
module stage_census
    import ray_sched_pkg::*;
#(
    parameter int NUM_RAYS = 8,
    localparam int CW = $clog2(NUM_RAYS + 1)
) (
    input  logic [NUM_RAYS*TAG_W-1:0] tags_i,
    output logic                      all_done_o,
    output logic [1:0]                pick_o
);

    logic [CW-1:0] wait_cnt [N_STAGES];

    // One population counter per live stage
    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        logic [CW-1:0] n;
        always_comb begin
            n = '0;
            for (int r = 0; r < NUM_RAYS; r++) begin
                if (tags_i[r*TAG_W +: TAG_W] == TAG_W'(s)) begin
                    n = n + CW'(1);
                end
            end
        end
        assign wait_cnt[s] = n;
    end

    always_comb begin
        all_done_o = 1'b1;
        for (int r = 0; r < NUM_RAYS; r++) begin
            if (tags_i[r*TAG_W +: TAG_W] != TAG_TERM) begin
                all_done_o = 1'b0;
            end
        end
    end

    // Strict comparisons keep the earlier stage on a tie:
    // intersection, traversal, shading, generation
    always_comb begin
        logic [1:0]    best;
        logic [CW-1:0] best_n;
        best   = TAG_ISECT[1:0];
        best_n = wait_cnt[2];
        if (wait_cnt[1] > best_n) begin
            best   = TAG_TRAV[1:0];
            best_n = wait_cnt[1];
        end
        if (wait_cnt[3] > best_n) begin
            best   = TAG_SHADE[1:0];
            best_n = wait_cnt[3];
        end
        if (wait_cnt[0] > best_n) begin
            best   = TAG_GEN[1:0];
            best_n = wait_cnt[0];
        end
        pick_o = best;
    end

endmodule

// File: rtl/pass_sequencer.sv
module pass_sequencer
    import ray_sched_pkg::*;
#(
    parameter int NUM_RAYS   = 8,
    parameter int KERNEL_LAT = 2,
    localparam int IDW = (NUM_RAYS > 1) ? $clog2(NUM_RAYS) : 1,
    localparam int CW  = $clog2(NUM_RAYS + 1),
    localparam int DW  = (KERNEL_LAT > 1) ? $clog2(KERNEL_LAT) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic [NUM_RAYS*TAG_W-1:0] tags_i,
    input  logic                      all_done_i,
    input  logic [1:0]                pick_i,
    input  logic                      res_valid,
    input  logic [IDW-1:0]            res_id,
    input  logic [1:0]                res_code,
    output logic                      issue_valid,
    output logic [IDW-1:0]            issue_id,
    output logic                      wr_en,
    output logic [IDW-1:0]            wr_id,
    output logic [TAG_W-1:0]          wr_tag,
    output logic                      pass_active,
    output logic [1:0]                pass_kernel,
    output logic [CW-1:0]             pass_count,
    output logic                      pass_done,
    output logic                      frame_done
);

    typedef struct packed {
        phase_e              ph;
        logic [1:0]          kern;
        logic [IDW-1:0]      idx;
        logic [DW-1:0]       drain;
        logic [NUM_RAYS-1:0] issued;
        logic [CW-1:0]       cnt;
        logic                pass_done;
        logic                frame_done;
    } seq_t;

    seq_t q, d;

    logic [TAG_W-1:0] cur_tag;
    logic             in_window;
    logic             accept;

    assign cur_tag   = tags_i[q.idx*TAG_W +: TAG_W];
    assign in_window = (q.ph == PH_SCAN) || (q.ph == PH_DRAIN);
    assign accept    = res_valid && in_window && (int'(res_id) < NUM_RAYS)
                       && q.issued[res_id];

    always_comb begin
        d            = q;
        d.pass_done  = 1'b0;
        d.frame_done = 1'b0;
        issue_valid  = 1'b0;
        wr_en        = 1'b0;
        wr_id        = res_id;
        wr_tag       = advance_tag(q.kern, res_code);

        // Write-back of an outcome for a ray issued in this pass
        if (accept) begin
            wr_en             = 1'b1;
            d.issued[res_id]  = 1'b0;
        end

        unique case (q.ph)
            PH_IDLE: ;
            PH_PICK: begin
                if (all_done_i) begin
                    d.frame_done = 1'b1;
                    d.ph         = PH_IDLE;
                end else begin
                    d.kern   = pick_i;
                    d.idx    = '0;
                    d.cnt    = '0;
                    d.issued = '0;
                    d.ph     = PH_SCAN;
                end
            end
            PH_SCAN: begin
                if (cur_tag == {1'b0, q.kern}) begin
                    issue_valid     = 1'b1;
                    d.issued[q.idx] = 1'b1;
                    d.cnt           = q.cnt + CW'(1);
                end
                if (q.idx == IDW'(NUM_RAYS - 1)) begin
                    d.ph    = PH_DRAIN;
                    d.drain = DW'(KERNEL_LAT - 1);
                end else begin
                    d.idx = q.idx + IDW'(1);
                end
            end
            PH_DRAIN: begin
                if (q.drain == '0) begin
                    d.ph        = PH_PICK;
                    d.pass_done = 1'b1;
                end else begin
                    d.drain = q.drain - DW'(1);
                end
            end
            default: d.ph = PH_IDLE;
        endcase

        // A new frame overrides whatever the pass was doing
        if (frame_start) begin
            d.ph         = PH_PICK;
            d.issued     = '0;
            d.pass_done  = 1'b0;
            d.frame_done = 1'b0;
            issue_valid  = 1'b0;
            wr_en        = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, kern: 2'd0, idx: '0, drain: '0, issued: '0,
                   cnt: '0, pass_done: 1'b0, frame_done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign issue_id    = q.idx;
    assign pass_active = in_window;
    assign pass_kernel = q.kern;
    assign pass_count  = q.cnt;
    assign pass_done   = q.pass_done;
    assign frame_done  = q.frame_done;

endmodule

// File: rtl/ray_pass_scheduler.sv
module ray_pass_scheduler
    import ray_sched_pkg::*;
#(
    parameter int NUM_RAYS   = 8,
    parameter int KERNEL_LAT = 2,
    localparam int IDW = (NUM_RAYS > 1) ? $clog2(NUM_RAYS) : 1,
    localparam int CW  = $clog2(NUM_RAYS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_start,
    output logic           issue_valid,
    output logic [IDW-1:0] issue_id,
    input  logic           res_valid,
    input  logic [IDW-1:0] res_id,
    input  logic [1:0]     res_code,
    output logic           pass_active,
    output logic [1:0]     pass_kernel,
    output logic [CW-1:0]  pass_count,
    output logic           pass_done,
    output logic           frame_done
);

    logic [NUM_RAYS*TAG_W-1:0] tag_flat;
    logic                      wr_en;
    logic [IDW-1:0]            wr_id;
    logic [TAG_W-1:0]          wr_tag;
    logic                      all_done;
    logic [1:0]                pick;

    ray_tag_store #(.NUM_RAYS(NUM_RAYS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (frame_start),
        .wr_en     (wr_en),
        .wr_id     (wr_id),
        .wr_tag    (wr_tag),
        .tags_o    (tag_flat)
    );

    stage_census #(.NUM_RAYS(NUM_RAYS)) u_census (
        .tags_i     (tag_flat),
        .all_done_o (all_done),
        .pick_o     (pick)
    );

    pass_sequencer #(.NUM_RAYS(NUM_RAYS), .KERNEL_LAT(KERNEL_LAT)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .tags_i      (tag_flat),
        .all_done_i  (all_done),
        .pick_i      (pick),
        .res_valid   (res_valid),
        .res_id      (res_id),
        .res_code    (res_code),
        .issue_valid (issue_valid),
        .issue_id    (issue_id),
        .wr_en       (wr_en),
        .wr_id       (wr_id),
        .wr_tag      (wr_tag),
        .pass_active (pass_active),
        .pass_kernel (pass_kernel),
        .pass_count  (pass_count),
        .pass_done   (pass_done),
        .frame_done  (frame_done)
    );

endmodule

// File: rtl/ray_pass_scheduler_chk.sv
module ray_pass_scheduler_chk
    import ray_sched_pkg::*;
#(
    parameter int NUM_RAYS   = 8,
    parameter int KERNEL_LAT = 2,
    localparam int IDW = (NUM_RAYS > 1) ? $clog2(NUM_RAYS) : 1,
    localparam int CW  = $clog2(NUM_RAYS + 1),
    localparam int AW  = $clog2(NUM_RAYS + KERNEL_LAT + 2)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      frame_start,
    input logic                      issue_valid,
    input logic [IDW-1:0]            issue_id,
    input logic                      pass_active,
    input logic [1:0]                pass_kernel,
    input logic [CW-1:0]             pass_count,
    input logic                      pass_done,
    input logic                      frame_done,
    input logic [NUM_RAYS*TAG_W-1:0] tag_flat
);

    logic [AW-1:0]    act_q;
    logic [TAG_W-1:0] issued_tag;
    logic             all_term;

    always_ff @(posedge clk) begin
        if (!rst_n)           act_q <= '0;
        else if (pass_active) act_q <= act_q + AW'(1);
        else                  act_q <= '0;
    end

    assign issued_tag = tag_flat[issue_id*TAG_W +: TAG_W];

    always_comb begin
        all_term = 1'b1;
        for (int r = 0; r < NUM_RAYS; r++) begin
            if (tag_flat[r*TAG_W +: TAG_W] != TAG_TERM) all_term = 1'b0;
        end
    end

    AST_ISSUE_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> pass_active) else $error("issue outside pass"); // R2

    AST_ISSUE_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> issued_tag == {1'b0, pass_kernel}) else $error("issued ray in wrong stage"); // R3

    for (genvar r = 0; r < NUM_RAYS; r++) begin : g_hold
        AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (pass_active && !frame_start && tag_flat[r*TAG_W +: TAG_W] != {1'b0, pass_kernel})
            |=> $stable(tag_flat[r*TAG_W +: TAG_W])) else $error("masked tag changed"); // R3
    end

    AST_PASS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_active && act_q != '0 && !$past(frame_start))
        |-> act_q == AW'(NUM_RAYS + KERNEL_LAT)) else $error("pass length wrong"); // R2

    AST_DONE_AFTER_FULL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> (act_q == AW'(NUM_RAYS + KERNEL_LAT) && !pass_active)) else $error("pass_done misplaced"); // R8

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_count <= CW'(NUM_RAYS)) else $error("pass count too large"); // R8

    AST_FRAME_DONE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (all_term && !pass_active)) else $error("frame done with live rays"); // R10

    AST_FRAME_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done) else $error("frame done not a pulse"); // R10

endmodule

bind ray_pass_scheduler ray_pass_scheduler_chk #(
    .NUM_RAYS   (NUM_RAYS),
    .KERNEL_LAT (KERNEL_LAT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .issue_valid (issue_valid),
    .issue_id    (issue_id),
    .pass_active (pass_active),
    .pass_kernel (pass_kernel),
    .pass_count  (pass_count),
    .pass_done   (pass_done),
    .frame_done  (frame_done),
    .tag_flat    (tag_flat)
);

// File: tb/ray_pass_scheduler_test.sv
module ray_pass_scheduler_test;

    localparam int N   = 8;
    localparam int LAT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       issue_valid;
    logic [2:0] issue_id;
    logic       res_valid = 1'b0;
    logic [2:0] res_id = '0;
    logic [1:0] res_code = '0;
    logic       pass_active;
    logic [1:0] pass_kernel;
    logic [3:0] pass_count;
    logic       pass_done;
    logic       frame_done;

    always #5 clk = ~clk;

    ray_pass_scheduler #(.NUM_RAYS(N), .KERNEL_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .issue_valid(issue_valid), .issue_id(issue_id),
        .res_valid(res_valid), .res_id(res_id), .res_code(res_code),
        .pass_active(pass_active), .pass_kernel(pass_kernel),
        .pass_count(pass_count), .pass_done(pass_done), .frame_done(frame_done)
    );

    // {expected kernel, expected count, outcome code per ray (ray r at bits 2r+1:2r)}
    localparam logic [21:0] PASS_TAB [9] = '{
        {2'd0, 4'd8, 16'h0555},   // R4: rays 0-5 hit box, 6 and 7 miss
        {2'd1, 4'd6, 16'h024A},   // R5: cell, cell, step, leave, cell, step
        {2'd2, 4'd3, 16'h0101},   // R6: ray0 hit, ray1 miss, ray4 hit
        {2'd1, 4'd3, 16'h0428},   // R5
        {2'd2, 4'd2, 16'h0014},   // R9 tie intersection vs shading
        {2'd3, 4'd4, 16'h0101},   // R7: ray0, ray4 spawn
        {2'd1, 4'd2, 16'h0201},
        {2'd2, 4'd1, 16'h0000},   // R6 miss back to traversal
        {2'd1, 4'd1, 16'h0100}
    };

    int n_checks = 0;
    int n_fail   = 0;

    logic [2:0]  mtag [N];
    logic [15:0] cur_codes = '0;
    bit          pv [LAT];
    logic [2:0]  pid [LAT];
    logic [1:0]  pcode [LAT];
    bit          inj_v = 0;
    logic [2:0]  inj_id = '0;
    logic [1:0]  inj_code = '0;
    bit          fs_req = 0;
    int          act_cycles;
    int          issues;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] mnext(input logic [1:0] k, input logic [1:0] c);
        case (k)
            2'd0: return c[0] ? 3'd1 : 3'd7;
            2'd1: return (c == 2'b01) ? 3'd7 : ((c == 2'b10) ? 3'd2 : 3'd1);
            2'd2: return c[0] ? 3'd3 : 3'd1;
            default: return c[0] ? 3'd1 : 3'd7;
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] k);
        case (k)
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    // One cycle: observe outputs, act as the kernel with fixed latency LAT
    task automatic tick();
        bit         ov;
        logic [2:0] oid;
        logic [1:0] oc;
        @(negedge clk);
        if (pass_active) act_cycles++;
        if (issue_valid) begin
            issues++;
            check(mtag[issue_id] == {1'b0, pass_kernel}, "R3", "issued ray stage",
                  int'(mtag[issue_id]), int'(pass_kernel));
        end
        ov  = pv[LAT-1];
        oid = pid[LAT-1];
        oc  = pcode[LAT-1];
        for (int k = LAT-1; k > 0; k--) begin
            pv[k] = pv[k-1]; pid[k] = pid[k-1]; pcode[k] = pcode[k-1];
        end
        pv[0]    = issue_valid;
        pid[0]   = issue_id;
        pcode[0] = cur_codes[2*issue_id +: 2];
        if (ov) begin
            res_valid = 1'b1; res_id = oid; res_code = oc;
            mtag[oid] = mnext(pass_kernel, oc);
        end else if (inj_v) begin
            res_valid = 1'b1; res_id = inj_id; res_code = inj_code;
            inj_v = 0;
        end else begin
            res_valid = 1'b0;
        end
        frame_start = fs_req;
        fs_req = 0;
    endtask

    task automatic start_frame();
        fs_req = 1;
        tick();
        for (int k = 0; k < LAT; k++) pv[k] = 0;
        for (int r = 0; r < N; r++) mtag[r] = 3'd0;
    endtask

    task automatic run_pass(input logic [1:0] ek, input int ec, input logic [15:0] codes,
                            input string kreq);
        bit seen = 0;
        cur_codes  = codes;
        act_cycles = 0;
        issues     = 0;
        for (int t = 0; t < 4*(N+LAT) && !seen; t++) begin
            tick();
            if (pass_done) seen = 1;
        end
        check(seen, "R8", "pass_done seen", int'(seen), 1);
        check(pass_kernel == ek, kreq, "kernel chosen", int'(pass_kernel), int'(ek));
        check(int'(pass_count) == ec, "R8", "pass_count", int'(pass_count), ec);
        check(issues == ec, "R3", "rays issued", issues, ec);
        check(act_cycles == N+LAT, "R2", "pass length", act_cycles, N+LAT);
    endtask

    task automatic wait_frame_done(input string req);
        bit seen = 0;
        bit extra = 0;
        for (int t = 0; t < 6; t++) begin
            tick();
            if (frame_done) seen = 1;
            if (pass_active) extra = 1;
        end
        check(seen, "R10", {req, " frame_done pulse"}, int'(seen), 1);
        check(!extra, "R10", {req, " no pass after all terminated"}, int'(extra), 0);
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks + 1, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < LAT; k++) begin pv[k] = 0; pid[k] = '0; pcode[k] = '0; end
        for (int r = 0; r < N; r++) mtag[r] = 3'd7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: idle after reset
        for (int t = 0; t < 3; t++) begin
            tick();
            check(!pass_active && !issue_valid && !pass_done && !frame_done && pass_count == 0,
                  "R11", "idle outputs after reset",
                  int'({pass_active, issue_valid, pass_done, frame_done}), 0);
        end

        // Frame 1: table walk, R1 first entry
        start_frame();
        for (int v = 0; v < 9; v++) begin
            logic [1:0] ek;
            ek = PASS_TAB[v][21:20];
            run_pass(ek, int'(PASS_TAB[v][19:16]), PASS_TAB[v][15:0],
                     (v == 0) ? "R1" : ((v == 4) ? "R9" : req_of(PASS_TAB[v-1][21:20])));
        end
        wait_frame_done("R7");

        // Frame 2: stray results must be ignored (R3)
        start_frame();
        run_pass(2'd0, 8, 16'h1555, "R1");
        res_valid = 1'b1; res_id = 3'd0; res_code = 2'b00;   // in pick cycle
        inj_v = 1; inj_id = 3'd7; inj_code = 2'b10;         // ray7 terminated, masked
        run_pass(2'd1, 7, 16'h1555, "R3");
        wait_frame_done("R3");

        // Frame 3: restart in the middle of a pass (R1)
        start_frame();
        repeat (4) tick();
        start_frame();
        run_pass(2'd0, 8, 16'h0000, "R1");
        wait_frame_done("R1");

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule